// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block brings a DDR2 SDRAM from reset to normal operation without software help. Once reset is released it turns on the PHY delay-locked loop, starts it, and waits until the PHY reports both its clock lock and its frequency lock. It then holds the memory clock running for a programmable power-up interval. After that it walks a fixed list of thirteen memory commands that wake the device, clear its banks, program the extended and main mode registers, reset and re-lock the device DLL, refresh twice, and step the off-chip driver calibration through its default and exit codes.

Commands leave through a 32-bit command word with a one-cycle valid strobe. A command controller answers with a busy flag. The sequencer never strobes while busy is high, and it treats a command as finished only when busy reads low again. Timed gaps measured in microsecond ticks separate the steps that need settling time. A final done flag tells the controller that auto-refresh may start. If lock never arrives, a timeout raises a sticky error and the list is never started. The CAS latency and write recovery inputs shape the mode-register word.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is held, cmd_valid, dll_en, dll_start, init_done and init_err are all low.
- R2: After reset, dll_en rises first and dll_start rises exactly one cycle later. Both then stay high. dll_point and dll_step both carry 0x28.
- R3: No command is issued until phy_lock equals 2'b11. phy_lock[1] is the clock lock and phy_lock[0] is the frequency lock. One lock bit on its own does not advance the sequence.
- R4: If lock is not seen within LOCK_TIMEOUT_US microsecond ticks after dll_start rises, init_err goes high the cycle after the last of those ticks. It stays high, and no command and no done ever follow.
- R5: The first command is strobed after exactly POWERUP_US ticks counted from the cycle lock is seen, unless busy is still high then. In that case it is strobed later.
- R6: The commands go out in this order, with these encodings:
  - wake 0x10000000
  - NOP 0x20000000
  - precharge-all 0x30000000
  - EMR2 0xA0000000
  - EMR3 0xB0000000
  - EMR1 0x90000006 (75-ohm termination bit 2, reduced drive bit 1, DLL enabled with bit 0 low)
  - mode word plus 0x100 (DLL reset)
  - precharge-all
  - refresh 0x40000000
  - refresh
  - mode word
  - EMR1 plus 0x380 (OCD default), giving 0x90000386
  - EMR1 plus 0 (OCD exit), giving 0x90000006
- R7: The mode word is 0x80200003 + cas_lat*16 + (wr_rec-1)*512. This selects burst length 8.
- R8: The DLL-reset mode write, the following precharge-all, both refreshes, the plain mode write and the OCD-default write are each preceded by exactly GAP_US ticks, counted after the previous command completes.
- R9: cmd_valid is a one-cycle pulse, never issued in a cycle where cmd_busy is high. A command completes in the first cycle after its strobe in which cmd_busy is low. The controller must raise busy in the cycle after it samples the strobe.
- R10: init_done rises in the cycle after the last command completes and holds until reset. No command follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | 4 | CAS latency for the mode word |
| wr_rec | input | 4 | Write recovery in clocks for the mode word |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| phy_lock | input | 2 | PHY lock status: [1] clock lock, [0] frequency lock |
| cmd_busy | input | 1 | Command controller busy |
| cmd_word | output | 32 | Command word, valid with the strobe |
| cmd_valid | output | 1 | One-cycle command strobe |
| dll_en | output | 1 | PHY DLL enable |
| dll_start | output | 1 | PHY DLL start |
| dll_point | output | 8 | PHY DLL start point |
| dll_step | output | 8 | PHY DLL increment |
| init_done | output | 1 | Sequence finished; auto-refresh may run |
| init_err | output | 1 | Lock timeout; sequence abandoned |

## Verification
The sequence is run three times.

The first run uses CAS latency 6 and write recovery 6. Busy is held high past the end of the power-up interval, which shows that the strobe waits on busy rather than on the timer alone.

The second run never supplies lock, which separates the timeout path from the normal path and pins the exact tick on which the error rises.

The third run uses CAS latency 4 and write recovery 4. It raises a single lock bit first, then both bits, so it shows that partial lock is rejected. The two runs that complete produce different mode words, which shows that the inputs feed the word. In both of those runs the controller busy length varies from command to command, and every gap is counted in ticks against its required value.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

    localparam int NUM_STEPS = 13;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int CMD_W     = 32;

    // command encodings
    localparam logic [CMD_W-1:0] OP_WAKE     = 32'h1000_0000;
    localparam logic [CMD_W-1:0] OP_NOP      = 32'h2000_0000;
    localparam logic [CMD_W-1:0] OP_PREA     = 32'h3000_0000;
    localparam logic [CMD_W-1:0] OP_REFRESH  = 32'h4000_0000;
    localparam logic [CMD_W-1:0] OP_EMR2     = 32'hA000_0000;
    localparam logic [CMD_W-1:0] OP_EMR3     = 32'hB000_0000;
    localparam logic [CMD_W-1:0] OP_EMR1     = 32'h9000_0000;
    localparam logic [CMD_W-1:0] EMR1_ODT75  = 32'h0000_0004;
    localparam logic [CMD_W-1:0] EMR1_WEAK   = 32'h0000_0002;
    localparam logic [CMD_W-1:0] OCD_DEFAULT = 32'h0000_0380;
    localparam logic [CMD_W-1:0] OCD_LEAVE   = 32'h0000_0000;
    localparam logic [CMD_W-1:0] MR_BASE     = 32'h8020_0003;
    localparam logic [CMD_W-1:0] MR_DLL_RST  = 32'h0000_0100;

    typedef enum logic [3:0] {
        ST_DLL_ON, ST_DLL_GO, ST_LOCK, ST_PWRUP, ST_ISSUE,
        ST_SENT, ST_BUSY, ST_GAP, ST_DONE, ST_ERR
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [CMD_W-1:0]  cmd;
        logic              valid;
        logic              dll_en;
        logic              dll_start;
        logic              done;
        logic              err;
    } seq_regs_t;

endpackage

// File: rtl/ddr2_us_timer.sv
module ddr2_us_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R8: each tick removes exactly one unit while the count is live
    a_r8_tick_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !expired) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/ddr2_cmd_table.sv
module ddr2_cmd_table
    import ddr2_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [3:0]        cas_lat,
    input  logic [3:0]        wr_rec,
    output logic [CMD_W-1:0]  word,
    output logic              gap_after,
    output logic              last
);
    logic [CMD_W-1:0] mode_word;
    logic [CMD_W-1:0] emr1_word;

    assign mode_word = MR_BASE + (CMD_W'(cas_lat) << 4)
                     + ((CMD_W'(wr_rec) - CMD_W'(1)) << 9);
    assign emr1_word = OP_EMR1 | EMR1_ODT75 | EMR1_WEAK;

    always_comb begin
        case (step)
            STEP_W'(0):  word = OP_WAKE;
            STEP_W'(1):  word = OP_NOP;
            STEP_W'(2):  word = OP_PREA;
            STEP_W'(3):  word = OP_EMR2;
            STEP_W'(4):  word = OP_EMR3;
            STEP_W'(5):  word = emr1_word;
            STEP_W'(6):  word = mode_word + MR_DLL_RST;
            STEP_W'(7):  word = OP_PREA;
            STEP_W'(8):  word = OP_REFRESH;
            STEP_W'(9):  word = OP_REFRESH;
            STEP_W'(10): word = mode_word;
            STEP_W'(11): word = emr1_word + OCD_DEFAULT;
            default:     word = emr1_word + OCD_LEAVE;
        endcase
    end

    // settling gaps follow the EMR1 write through the plain mode write
    assign gap_after = (step >= STEP_W'(5)) && (step <= STEP_W'(10));
    assign last      = (step == STEP_W'(NUM_STEPS - 1));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_seq_pkg::*;
#(
    parameter int         POWERUP_US      = 200,
    parameter int         GAP_US          = 1,
    parameter int         LOCK_TIMEOUT_US = 1000,
    parameter logic [7:0] DLL_START_PT    = 8'h28,
    parameter logic [7:0] DLL_INC         = 8'h28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  cas_lat,
    input  logic [3:0]  wr_rec,
    input  logic        us_tick,
    input  logic [1:0]  phy_lock,
    input  logic        cmd_busy,
    output logic [31:0] cmd_word,
    output logic        cmd_valid,
    output logic        dll_en,
    output logic        dll_start,
    output logic [7:0]  dll_point,
    output logic [7:0]  dll_step,
    output logic        init_done,
    output logic        init_err
);
    localparam int T_A  = (POWERUP_US > LOCK_TIMEOUT_US) ? POWERUP_US : LOCK_TIMEOUT_US;
    localparam int TMAX = (GAP_US > T_A) ? GAP_US : T_A;
    localparam int CW   = $clog2(TMAX + 1);

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_done;
    logic [CMD_W-1:0] tbl_word;
    logic             tbl_gap, tbl_last;

    ddr2_cmd_table u_table (
        .step      (r_q.step),
        .cas_lat   (cas_lat),
        .wr_rec    (wr_rec),
        .word      (tbl_word),
        .gap_after (tbl_gap),
        .last      (tbl_last)
    );

    ddr2_us_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (us_tick),
        .expired  (tmr_done)
    );

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.state)
            ST_DLL_ON: begin
                r_d.dll_en = 1'b1;
                r_d.state  = ST_DLL_GO;
            end
            ST_DLL_GO: begin
                r_d.dll_start = 1'b1;
                r_d.state     = ST_LOCK;
                tmr_load      = 1'b1;
                tmr_val       = CW'(LOCK_TIMEOUT_US);
            end
            ST_LOCK: begin
                if (&phy_lock) begin
                    r_d.state = ST_PWRUP;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(POWERUP_US);
                end else if (tmr_done) begin
                    r_d.state = ST_ERR;
                    r_d.err   = 1'b1;
                end
            end
            ST_PWRUP: if (tmr_done) r_d.state = ST_ISSUE;
            ST_ISSUE: begin
                if (!cmd_busy) begin
                    r_d.valid = 1'b1;
                    r_d.cmd   = tbl_word;
                    r_d.state = ST_SENT;
                end
            end
            ST_SENT: r_d.state = ST_BUSY;
            ST_BUSY: begin
                if (!cmd_busy) begin
                    if (tbl_last) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.step = r_q.step + STEP_W'(1);
                        if (tbl_gap) begin
                            r_d.state = ST_GAP;
                            tmr_load  = 1'b1;
                            tmr_val   = CW'(GAP_US);
                        end else begin
                            r_d.state = ST_ISSUE;
                        end
                    end
                end
            end
            ST_GAP: if (tmr_done) r_d.state = ST_ISSUE;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_DLL_ON, step: '0, cmd: '0, default: 1'b0};
        else        r_q <= r_d;
    end

    assign cmd_word  = r_q.cmd;
    assign cmd_valid = r_q.valid;
    assign dll_en    = r_q.dll_en;
    assign dll_start = r_q.dll_start;
    assign dll_point = DLL_START_PT;
    assign dll_step  = DLL_INC;
    assign init_done = r_q.done;
    assign init_err  = r_q.err;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r9_idle_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(cmd_busy));
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !cmd_valid);
    a_r4_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> (init_err && !cmd_valid && !init_done));
    a_r2_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        dll_start |-> dll_en);
    a_r3_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOCK && !(&phy_lock)) |=>
            (r_q.state == ST_LOCK || r_q.state == ST_ERR));

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;
    localparam int PU = 20, GP = 2, TO = 30, TDIV = 5, NCMD = 13;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [3:0]  cl = 4'd6, wr = 4'd6;
    logic        us_tick = 1'b0;
    logic [1:0]  lock = 2'b00;
    logic        ext_busy = 1'b0, ctl_busy = 1'b0;
    logic        busy;
    logic [31:0] cmd_word;
    logic        cmd_valid, dll_en, dll_start, init_done, init_err;
    logic [7:0]  dll_point, dll_step;

    assign busy = ext_busy | ctl_busy;

    always #4 clk = ~clk;

    ddr2_init_seq #(.POWERUP_US(PU), .GAP_US(GP), .LOCK_TIMEOUT_US(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cas_lat(cl), .wr_rec(wr), .us_tick(us_tick),
        .phy_lock(lock), .cmd_busy(busy), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
        .dll_en(dll_en), .dll_start(dll_start), .dll_point(dll_point),
        .dll_step(dll_step), .init_done(init_done), .init_err(init_err)
    );

    int total = 0, bad = 0;
    int ncyc, idx, acc, acc_e, busy_left, done_mark, err_mark, tdiv_cnt, en_cyc;
    int mode, part_cyc, full_cyc, ext_until;
    bit active = 1'b0, cmp_next, last_cmp, start_seen, locked;
    logic busy_seen, tick_seen;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int i, logic [3:0] c, logic [3:0] w);
        logic [31:0] mw;
        mw = 32'h8020_0003 + 32'(c) * 16 + (32'(w) - 1) * 512;  // R7
        case (i)
            0: return 32'h1000_0000;
            1: return 32'h2000_0000;
            2, 7: return 32'h3000_0000;
            3: return 32'hA000_0000;
            4: return 32'hB000_0000;
            5, 12: return 32'h9000_0006;
            6: return mw + 32'h100;
            8, 9: return 32'h4000_0000;
            10: return mw;
            default: return 32'h9000_0386;
        endcase
    endfunction

    // reference model: controller, tick source, lock source and comparison
    always @(negedge clk) begin
        if (active) begin
            ncyc++;
            busy_seen = busy;
            tick_seen = us_tick;
            if (cmp_next) begin
                acc = 0; cmp_next = 1'b0;
                if (last_cmp) done_mark = ncyc;
            end else acc += int'(tick_seen);
            if (start_seen && !init_err) acc_e += int'(tick_seen);
            if (dll_en && en_cyc < 0) en_cyc = ncyc;
            if (dll_start && !start_seen) begin
                start_seen = 1'b1; acc_e = 0;
                chk(en_cyc == ncyc - 1, "R2", "dll_start one cycle after dll_en", ncyc - en_cyc, 1);
                chk(dll_point == 8'h28 && dll_step == 8'h28, "R2", "dll point/step",
                    {dll_point, dll_step}, 16'h2828);
            end
            if (start_seen) chk(dll_en && dll_start, "R2", "dll held", {dll_en, dll_start}, 2'b11);
            if (mode == 1 && start_seen && acc_e == TO && err_mark < 0) err_mark = ncyc;
            chk(init_err == (err_mark >= 0 && ncyc > err_mark), "R4", "init_err",
                init_err, (err_mark >= 0 && ncyc > err_mark));
            chk(init_done == (done_mark >= 0 && ncyc >= done_mark), "R10", "init_done",
                init_done, (done_mark >= 0 && ncyc >= done_mark));
            if (cmd_valid) begin
                chk(!busy_seen, "R9", "strobe while busy", busy_seen, 0);
                chk(locked, "R3", "strobe before full lock", lock, 2'b11);
                chk(idx < NCMD, "R10", "extra command", idx, NCMD - 1);
                if (idx < NCMD)
                    chk(cmd_word == exp_word(idx, cl, wr), (idx == 6 || idx == 10) ? "R7" : "R6",
                        $sformatf("word %0d", idx), cmd_word, exp_word(idx, cl, wr));
                if (idx == 0) begin
                    if (ext_until > 0) chk(acc >= PU, "R5", "power-up ticks (busy held)", acc, PU);
                    else               chk(acc == PU, "R5", "power-up ticks", acc, PU);
                end
                if (idx >= 6 && idx <= 11)
                    chk(acc == GP, "R8", $sformatf("gap before %0d", idx), acc, GP);
                idx++;
                busy_left = 1 + (idx % 3);
                ctl_busy = 1'b1;
            end else if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    ctl_busy = 1'b0; cmp_next = 1'b1; last_cmp = (idx == NCMD);
                end
            end
            ext_busy = (ncyc < ext_until);
            if (ncyc == part_cyc) lock = 2'b10;
            if (ncyc == full_cyc) begin
                lock = 2'b11; locked = 1'b1; cmp_next = 1'b1; last_cmp = 1'b0;
            end
            tdiv_cnt = (tdiv_cnt + 1) % TDIV;
            us_tick = (tdiv_cnt == 0);
        end
    end

    task automatic do_run(input logic [3:0] c, input logic [3:0] w, input int m,
                          input int pc, input int fc, input int eu, input int len);
        active = 1'b0;
        @(posedge clk);
        rst_n = 1'b0;
        cl = c; wr = w; mode = m; part_cyc = pc; full_cyc = fc; ext_until = eu;
        ncyc = 0; idx = 0; acc = 0; acc_e = 0; busy_left = 0; tdiv_cnt = 0;
        done_mark = -1; err_mark = -1; en_cyc = -1;
        cmp_next = 1'b0; last_cmp = 1'b0; start_seen = 1'b0; locked = 1'b0;
        lock = 2'b00; ctl_busy = 1'b0; ext_busy = 1'b0; us_tick = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk({cmd_valid, dll_en, dll_start, init_done, init_err} == 5'b0, "R1", "reset outputs",
            {cmd_valid, dll_en, dll_start, init_done, init_err}, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        active = 1'b1;
        repeat (len) @(posedge clk);
        if (m == 1) begin
            chk(init_err && idx == 0 && !init_done, "R4", "timeout end state",
                {init_err, init_done}, 2'b10);
        end else begin
            chk(idx == NCMD, "R6", "command count", idx, NCMD);
            chk(init_done && !init_err, "R10", "done end state", {init_done, init_err}, 2'b10);
        end
    endtask

    initial begin
        do_run(4'd6, 4'd6, 0, -1, 40, 170, 600);
        do_run(4'd5, 4'd3, 1, -1, -1, 0, 250);
        do_run(4'd4, 4'd4, 2, 20, 60, 0, 500);
        active = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule